// File: doc/BRIEF.md
# Bit-Matrix Product Unit

This unit reads each 64-bit operand as an 8x8 matrix of bits. Each byte is one row. It computes a matrix product of the two operands under one of three rules for combining bits. It can also return the transpose of the first operand. A single array of 64 dot-product cells serves all three products, and a 2-bit mode input picks the output.

The XOR product adds one constant bit per column, supplied by an 8-bit input. This gives an affine transform over GF(2). That form suits byte substitution, bit reversal and error-correcting code kernels. The OR and AND products give reachability-style and all-bits-match matrix combinations.

An operation is presented with a valid strobe, and its result appears on the registered output one clock later. While no strobe is present, the output holds its last value.

Top module: `bitmat_mul_unit`

## Requirements
- R1: While reset is asserted (active low), `out_valid` is 0 and `result` is all zeros.
- R2: Byte r of `mat_a` (byte 0 = bits 7:0, bit 0 = least significant bit of the byte) is row r of the first matrix. Column c of the second matrix is bit c of every byte of `mat_b`, taken from byte t for element t. Product bit index 8*r + c holds the combination of row r with column c.
- R3: Mode 0 (transpose) puts bit k of byte j of `mat_a` at bit j of byte k of `result`.
- R4: Mode 1 (XOR product) sets bit 8*r+c to `xor_const[c]` XOR the parity of (row r AND column c).
- R5: Mode 2 (OR product) sets bit 8*r+c to 1 exactly when (row r AND column c) is nonzero.
- R6: Mode 3 (AND product) sets bit 8*r+c to 1 exactly when (row r AND column c) has all eight bits set.
- R7: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. `result` is updated on that same clock edge.
- R8: When `in_valid` is low, `result` keeps its previous value whatever the other inputs do.
- R9: `xor_const` has no effect on the result in modes 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture an operation this cycle |
| mode | input | 2 | 0 transpose, 1 XOR product, 2 OR product, 3 AND product |
| mat_a | input | 64 | First matrix, one byte per row |
| mat_b | input | 64 | Second matrix, one byte per row |
| xor_const | input | 8 | Per-column constant for the XOR product |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Registered result matrix |

## Verification
A swapped index in either transpose shows up as a mirrored or shifted bit pattern in the very next result. A single-bit operand, an identity operand and a transpose-mode run expose such a swap within one operation. A faulty cell or mode selection corrupts only the bits of one row and column pair, or only one mode, so every strobed result is compared with an independent model over many random operands and all four modes. Faults in the hold path and the valid pipeline appear one cycle after the strobe drops: the output changes even though no strobe was given.

// File: rtl/bmm_pkg.sv
package bmm_pkg;

  typedef enum logic [1:0] {
    BMM_FLIP = 2'd0,
    BMM_XOR  = 2'd1,
    BMM_OR   = 2'd2,
    BMM_AND  = 2'd3
  } bmm_mode_e;

endpackage

// File: rtl/bmm_transpose.sv
module bmm_transpose #(
  parameter int DIM = 8
) (
  input  logic [DIM*DIM-1:0] mat_i,
  output logic [DIM*DIM-1:0] mat_o
);
  // element (row j, col k) moves to (row k, col j)
  for (genvar j = 0; j < DIM; j++) begin : g_row
    for (genvar k = 0; k < DIM; k++) begin : g_col
      assign mat_o[k*DIM + j] = mat_i[j*DIM + k];
    end
  end
endmodule

// File: rtl/bmm_dot_cell.sv
module bmm_dot_cell #(
  parameter int DIM = 8
) (
  input  logic [DIM-1:0] row_i,
  input  logic [DIM-1:0] col_i,
  input  logic           kbit_i,
  output logic           xor_o,
  output logic           or_o,
  output logic           and_o
);
  function automatic logic odd_ones(input logic [DIM-1:0] v);
    return ^v;
  endfunction

  function automatic logic any_one(input logic [DIM-1:0] v);
    return |v;
  endfunction

  function automatic logic all_ones(input logic [DIM-1:0] v);
    return &v;
  endfunction

  logic [DIM-1:0] meet;
  assign meet  = row_i & col_i;
  assign xor_o = kbit_i ^ odd_ones(meet);
  assign or_o  = any_one(meet);
  assign and_o = all_ones(meet);
endmodule

// File: rtl/bitmat_mul_unit.sv
module bitmat_mul_unit #(
  parameter int DIM = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          mode,
  input  logic [DIM*DIM-1:0]  mat_a,
  input  logic [DIM*DIM-1:0]  mat_b,
  input  logic [DIM-1:0]      xor_const,
  output logic                out_valid,
  output logic [DIM*DIM-1:0]  result
);
  import bmm_pkg::*;

  localparam int W = DIM * DIM;

  logic [W-1:0] a_flip;
  logic [W-1:0] b_cols;
  logic [W-1:0] cell_xor;
  logic [W-1:0] cell_or;
  logic [W-1:0] cell_and;
  logic [W-1:0] next_res;
  logic         capture;
  bmm_mode_e    sel;

  assign sel     = bmm_mode_e'(mode);
  assign capture = in_valid;

  bmm_transpose #(.DIM(DIM)) u_flip_a (.mat_i(mat_a), .mat_o(a_flip));
  bmm_transpose #(.DIM(DIM)) u_flip_b (.mat_i(mat_b), .mat_o(b_cols));

  for (genvar r = 0; r < DIM; r++) begin : g_r
    for (genvar c = 0; c < DIM; c++) begin : g_c
      bmm_dot_cell #(.DIM(DIM)) u_cell (
        .row_i  (mat_a[r*DIM +: DIM]),
        .col_i  (b_cols[c*DIM +: DIM]),
        .kbit_i (xor_const[c]),
        .xor_o  (cell_xor[r*DIM + c]),
        .or_o   (cell_or[r*DIM + c]),
        .and_o  (cell_and[r*DIM + c])
      );
    end
  end

  always_comb begin
    case (sel)
      BMM_FLIP: next_res = a_flip;
      BMM_XOR:  next_res = cell_xor;
      BMM_OR:   next_res = cell_or;
      default:  next_res = cell_and;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= capture;
      if (capture) result <= next_res;
    end
  end

  // R7: strobe produces valid exactly one cycle later
  a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8: no strobe, result frozen and valid low
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && !out_valid));
  // R6: an all-ones meet is always also a nonzero meet
  a_r6_and_implies_or: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((cell_and & ~cell_or) == '0));
  // R4: zero first operand leaves only the column constant, repeated per row
  a_r4_zero_a_gives_const: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1 && mat_a == '0) |=> (result == {DIM{$past(xor_const)}}));
  // R5: zero second operand gives an empty OR product
  a_r5_or_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && mat_b == '0) |=> (result == '0));
endmodule

// File: tb/bitmat_mul_unit_bench.sv
`timescale 1ns/1ps
module bitmat_mul_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [63:0] mat_a = '0;
  logic [63:0] mat_b = '0;
  logic [7:0]  xor_const = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bitmat_mul_unit u_bitmat_mul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .mat_a(mat_a), .mat_b(mat_b), .xor_const(xor_const),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] ref_calc(input logic [1:0] m, input logic [63:0] a,
                                          input logic [63:0] b, input logic [7:0] k);
    logic [63:0] acc = '0;
    for (int ri = 0; ri < 8; ri++) begin
      for (int ci = 0; ci < 8; ci++) begin
        int ones = 0;
        for (int t = 0; t < 8; t++) ones += (a[8*ri+t] & b[8*t+ci]) ? 1 : 0;
        case (m)
          2'd0: acc[8*ri+ci] = a[8*ci+ri];
          2'd1: acc[8*ri+ci] = ((ones % 2) == 1) ^ k[ci];
          2'd2: acc[8*ri+ci] = (ones != 0);
          default: acc[8*ri+ci] = (ones == 8);
        endcase
      end
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle reference model
  logic        exp_valid = 1'b0;
  logic [63:0] exp_res = '0;
  logic [1:0]  exp_mode = 2'd0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_res   <= '0;
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_res  <= ref_calc(mode, mat_a, mat_b, xor_const);
        exp_mode <= mode;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string tag;
      chk(out_valid === exp_valid, "R7", {63'd0, out_valid}, {63'd0, exp_valid});
      if (!exp_valid) tag = "R8";
      else case (exp_mode)
        2'd0: tag = "R3";
        2'd1: tag = "R4";
        2'd2: tag = "R5";
        default: tag = "R6";
      endcase
      chk(result === exp_res, tag, result, exp_res);
    end
  end

  task automatic apply(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] k);
    @(negedge clk);
    mode = m; mat_a = a; mat_b = b; xor_const = k; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  localparam logic [63:0] IDENT = 64'h8040201008040201;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep;
    logic [63:0] r0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid === 1'b0, "R1", {63'd0, out_valid}, 64'd0);
    chk(result === 64'd0, "R1", result, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2: single bit at byte 0 bit 1 transposes to byte 1 bit 0
    apply(2'd0, 64'h2, 64'h0, 8'h00);
    chk(result === 64'h100, "R2", result, 64'h100);
    // R3: identity is its own transpose
    apply(2'd0, IDENT, 64'h0, 8'h00);
    chk(result === IDENT, "R3", result, IDENT);
    // R2/R4: identity times B gives B, plus constant per column
    apply(2'd1, IDENT, 64'h0123456789ABCDEF, 8'h00);
    chk(result === 64'h0123456789ABCDEF, "R2", result, 64'h0123456789ABCDEF);
    apply(2'd1, IDENT, 64'h0123456789ABCDEF, 8'hF0);
    chk(result === (64'h0123456789ABCDEF ^ {8{8'hF0}}), "R4", result,
        64'h0123456789ABCDEF ^ {8{8'hF0}});
    // R5: OR product of all-ones row with single-bit column rows
    apply(2'd2, 64'hFF, 64'h0000000000000001, 8'h00);
    chk(result === 64'h1, "R5", result, 64'h1);
    // R6: AND product needs every bit
    apply(2'd3, {64{1'b1}}, {64{1'b1}}, 8'h00);
    chk(result === {64{1'b1}}, "R6", result, {64{1'b1}});
    apply(2'd3, {64{1'b1}}, 64'hFFFFFFFFFFFFFFFE, 8'h00);
    chk(result === 64'hFEFEFEFEFEFEFEFE, "R6", result, 64'hFEFEFEFEFEFEFEFE);

    // R9: constant ignored outside XOR mode
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      apply(2'(m), 64'h3C5A96F00F1E2D4B, 64'h7766554433221100, 8'h00);
      r0 = result;
      apply(2'(m), 64'h3C5A96F00F1E2D4B, 64'h7766554433221100, 8'hA5);
      chk(result === r0, "R9", result, r0);
    end

    // R8: hold while inputs wander without a strobe
    keep = result;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      mat_a = {$urandom, $urandom}; mat_b = {$urandom, $urandom};
      mode = 2'($urandom); xor_const = 8'($urandom);
    end
    @(negedge clk);
    chk(result === keep, "R8", result, keep);

    // random traffic, every clock compared against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      mode = 2'($urandom); xor_const = 8'($urandom);
      mat_a = {$urandom, $urandom};
      mat_b = {$urandom, $urandom};
      if (($urandom % 8) == 0) mat_a = '0;
      if (($urandom % 8) == 0) mat_b = {64{1'b1}};
      in_valid = ($urandom % 4) != 0;
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule